// File: doc/BRIEF.md
# Clock-Activity Link Power Controller

This block decides which of three power states a serial video link sits in: off, idle-and-ready, or running. An asynchronous shutdown request, active low, forces the off state no matter what the link clock does. When shutdown is released, the block waits in the ready state until it sees the link clock toggling. It then runs the link and enables the datapath. If the link clock goes quiet while the link is running, the block drops back to the ready state and floats the parallel data outputs.

Clock activity is judged entirely in a free-running reference clock domain. The link clock is passed through a synchronizer and its rising edges are counted in fixed reference windows. Activity is declared once enough edges land in one window. The link is entered only after a run of complete qualifying windows. Inactivity is declared after a stretch of reference cycles with no edge at all. The shutdown input also goes through a two-flop synchronizer, and the state is published as a 2-bit code.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, `pwr_state` is 2'b00, and `clk_act`, `dp_en` and `out_oe` are 0, with no clock edge needed.
- R2: When `shdn_n` goes low, `pwr_state` reads 2'b00 (off) by the third rising `ref_clk` edge after the change, with `dp_en` and `out_oe` at 0. It stays there as long as `shdn_n` is low, even while `lclk` runs.
- R3: With `shdn_n` high and `lclk` stopped, `pwr_state` settles to 2'b01 (standby) with `dp_en`, `out_oe` and `clk_act` at 0.
- R4: `clk_act` rises once EDGE_MIN (4) rising `lclk` edges fall inside one aligned window of WIN (64) reference cycles. A clock too slow to give that many edges per window leaves `clk_act` at 0 and the block in standby.
- R5: Standby moves to active (2'b10) only at the end of a window, after QUAL_WIN (2) consecutive complete windows that each held at least EDGE_MIN edges. Off never moves straight to active. Leaving off always passes through standby first.
- R6: In active, `pwr_state` is 2'b10 and `dp_en` and `out_oe` are both 1.
- R7: In active, once IDLE (64) reference cycles pass without a rising `lclk` edge, the block returns to standby, and `out_oe`, `dp_en` and `clk_act` drop to 0. Before that many cycles it stays active.
- R8: `pwr_state` never takes the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shdn_n | input | 1 | Asynchronous shutdown request, active low |
| lclk | input | 1 | Link clock under observation, asynchronous to ref_clk |
| pwr_state | output | 2 | 00 off, 01 standby, 10 active |
| clk_act | output | 1 | Link clock judged to be toggling |
| dp_en | output | 1 | Datapath enable |
| out_oe | output | 1 | Parallel output drive enable; 0 floats the outputs |

## Verification
The assertions rely on two assumptions about the inputs. First, `shdn_n` and `lclk` are seen only through their synchronizers. Second, `lclk` edges are at least a few reference cycles apart, so each rising edge is counted once. The bench runs the fast link clock at a period of six reference cycles and the slow one at forty, so every edge is resolvable. The bench changes `shdn_n` and `rst_n` only at falling reference edges, which keeps the shutdown latency count exact.

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl #(
  parameter int WIN      = 64,
  parameter int EDGE_MIN = 4,
  parameter int IDLE     = 64,
  parameter int QUAL_WIN = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       shdn_n,
  input  logic       lclk,
  output logic [1:0] pwr_state,
  output logic       clk_act,
  output logic       dp_en,
  output logic       out_oe
);

  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int EW = $clog2(EDGE_MIN + 1);
  localparam int IW = $clog2(IDLE + 1);
  localparam int QW = $clog2(QUAL_WIN + 1);

  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_STBY = 2'b01,
    ST_ACT  = 2'b10
  } pstate_t;

  pstate_t       state;
  logic          sd_s1, sd_s2;
  logic          lk_s1, lk_s2, lk_s3;
  logic [WW-1:0] wcnt;
  logic [EW-1:0] ecnt;
  logic [IW-1:0] icnt;
  logic [QW-1:0] qcnt;
  logic          rise, win_end, hit_now, good_win, idle_hit, go_act;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_s1 <= 1'b0;
      sd_s2 <= 1'b0;
      lk_s1 <= 1'b0;
      lk_s2 <= 1'b0;
      lk_s3 <= 1'b0;
    end else begin
      sd_s1 <= shdn_n;
      sd_s2 <= sd_s1;
      lk_s1 <= lclk;
      lk_s2 <= lk_s1;
      lk_s3 <= lk_s2;
    end
  end

  assign rise     = lk_s2 & ~lk_s3;
  assign win_end  = (wcnt == WW'(WIN - 1));
  assign hit_now  = rise && (ecnt == EW'(EDGE_MIN - 1));
  assign good_win = (ecnt == EW'(EDGE_MIN)) || hit_now;
  assign idle_hit = sd_s2 && !rise && (icnt == IW'(IDLE - 1));
  assign go_act   = (state == ST_STBY) && win_end && good_win &&
                    (qcnt == QW'(QUAL_WIN - 1));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)       wcnt <= '0;
    else if (win_end) wcnt <= '0;
    else              wcnt <= wcnt + WW'(1);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                                 ecnt <= '0;
    else if (!sd_s2 || win_end)                 ecnt <= '0;
    else if (rise && ecnt != EW'(EDGE_MIN))     ecnt <= ecnt + EW'(1);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                       icnt <= IW'(IDLE);
    else if (!sd_s2)                  icnt <= IW'(IDLE);
    else if (rise)                    icnt <= '0;
    else if (icnt != IW'(IDLE))       icnt <= icnt + IW'(1);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)        clk_act <= 1'b0;
    else if (!sd_s2)   clk_act <= 1'b0;
    else if (hit_now)  clk_act <= 1'b1;
    else if (idle_hit) clk_act <= 1'b0;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                           qcnt <= '0;
    else if (!sd_s2 || state != ST_STBY)  qcnt <= '0;
    else if (win_end)                     qcnt <= good_win ? qcnt + QW'(1) : '0;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)      state <= ST_OFF;
    else if (!sd_s2) state <= ST_OFF;
    else begin
      case (state)
        ST_OFF:  state <= ST_STBY;
        ST_STBY: if (go_act)   state <= ST_ACT;
        ST_ACT:  if (idle_hit) state <= ST_STBY;
        default: state <= ST_OFF;
      endcase
    end
  end

  assign pwr_state = state;
  assign dp_en     = (state == ST_ACT);
  assign out_oe    = (state == ST_ACT);

endmodule

// File: rtl/link_pwr_ctrl_chk.sv
module link_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state,
  input logic       sd_ok,
  input logic       win_end,
  input logic       idle_hit
);

  a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);

  a_r2_shdn_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_ok |=> state == 2'b00);

  a_r5_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'b00 |=> state != 2'b10);

  a_r5_enter_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'b01 && state == 2'b10) |-> $past(win_end));

  a_r7_exit_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'b10 && state == 2'b01) |-> $past(idle_hit));

endmodule

bind link_pwr_ctrl link_pwr_ctrl_chk u_chk (
  .clk     (ref_clk),
  .rst_n   (rst_n),
  .state   (pwr_state),
  .sd_ok   (sd_s2),
  .win_end (win_end),
  .idle_hit(idle_hit)
);

// File: tb/link_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module link_pwr_ctrl_tb;

  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       shdn_n  = 1'b1;
  logic       lclk    = 1'b0;
  logic [1:0] pwr_state;
  logic       clk_act, dp_en, out_oe;

  int checks = 0;
  int errors = 0;
  int lk_half = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] st;
    logic       en;
    logic       oe;
    logic       act;
    bit         act_chk;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 ref_clk = ~ref_clk;

  link_pwr_ctrl u_dut (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .shdn_n   (shdn_n),
    .lclk     (lclk),
    .pwr_state(pwr_state),
    .clk_act  (clk_act),
    .dp_en    (dp_en),
    .out_oe   (out_oe)
  );

  initial begin
    forever begin
      if (lk_half == 0) begin
        lclk = 1'b0;
        @(posedge ref_clk);
      end else begin
        #(lk_half * 5);
        lclk = ~lclk;
      end
    end
  end

  task automatic push(input logic [1:0] st, input logic en, input logic oe,
                      input logic act, input bit act_chk, input string tag);
    exp_t e;
    @(posedge ref_clk);
    #1;
    e.st = st; e.en = en; e.oe = oe; e.act = act; e.act_chk = act_chk; e.tag = tag;
    sb.push_back(e);
    @(negedge ref_clk);
    #0.1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge ref_clk);
  endtask

  always @(negedge ref_clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pwr_state !== e.st || dp_en !== e.en || out_oe !== e.oe ||
          (e.act_chk && clk_act !== e.act)) begin
        errors++;
        $display("FAIL %s: got st=%b en=%b oe=%b act=%b, expected st=%b en=%b oe=%b act=%b",
                 e.tag, pwr_state, dp_en, out_oe, clk_act, e.st, e.en, e.oe, e.act);
      end
    end
  end

  // R8: code 11 must never appear
  always @(negedge ref_clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pwr_state === 2'b11) begin
        errors++;
        $display("FAIL R8: got st=%b, expected not 11", pwr_state);
      end
    end
  end

  initial begin
    forever begin
      @(posedge ref_clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    push(2'b00, 0, 0, 0, 1, "R1 reset state");
    @(negedge ref_clk); rst_n = 1'b1;
    wait_cyc(10);
    push(2'b01, 0, 0, 0, 1, "R3 standby without clock");

    lk_half = 3;
    wait_cyc(40);
    push(2'b01, 0, 0, 0, 0, "R5 not active before two full windows");
    wait_cyc(250);
    push(2'b10, 1, 1, 1, 1, "R4 R6 active with running clock");

    lk_half = 0;
    wait_cyc(20);
    push(2'b10, 1, 1, 1, 1, "R7 still active before idle limit");
    wait_cyc(100);
    push(2'b01, 0, 0, 0, 1, "R7 back to standby, outputs floated");

    lk_half = 20;
    wait_cyc(500);
    push(2'b01, 0, 0, 0, 1, "R4 slow clock leaves standby");

    lk_half = 3;
    wait_cyc(300);
    push(2'b10, 1, 1, 1, 1, "R6 active again");

    @(negedge ref_clk); shdn_n = 1'b0;
    wait_cyc(2);
    push(2'b00, 0, 0, 0, 1, "R2 off by third edge");
    wait_cyc(300);
    push(2'b00, 0, 0, 0, 1, "R2 off while clock runs");

    @(negedge ref_clk); shdn_n = 1'b1;
    wait_cyc(2);
    push(2'b01, 0, 0, 0, 0, "R5 off passes through standby");
    wait_cyc(300);
    push(2'b10, 1, 1, 1, 1, "R6 active after release");

    @(negedge ref_clk); rst_n = 1'b0;
    #1;
    checks++;
    if (pwr_state !== 2'b00 || dp_en !== 1'b0 || out_oe !== 1'b0 || clk_act !== 1'b0) begin
      errors++;
      $display("FAIL R1 async reset: got st=%b en=%b oe=%b act=%b, expected 00 0 0 0",
               pwr_state, dp_en, out_oe, clk_act);
    end
    push(2'b00, 0, 0, 0, 1, "R1 held in reset");

    wait_cyc(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule